// File: doc/BRIEF.md
# Temperature-Compensated Trim Controller

This block turns signed temperature samples into a DAC code for the variable capacitor of a crystal oscillator. It holds a coarse table of trim codes, one code per half degree. When the temperature used for compensation changes, or when the user commits a new tuning offset, it fetches the two table codes that bracket the temperature. It interpolates between them to a sixteenth of a degree. It then adds the signed user offset, clamps the sum to the DAC range and loads it into the output register.

A small register file, reached through a byte-wide write port and a combinational read port, holds the user tuning value, a freeze control bit and a read-only copy of the latest temperature sample. While the freeze bit is set, samples are still captured but the temperature trim is held. Tuning writes stay live, so the base frequency can still be moved while the temperature trim stays fixed.

Top module: `tct_trim_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, `done` is 0 and every register address reads 0.
- R2: Reads are combinational. Address 0 returns {freeze, tune[14:8]}, address 1 returns tune[7:0], address 2 returns temp[11:4] and address 3 returns {temp[3:0], 4'b0000}, where temp is the last sample taken with `temp_valid`. Writes to addresses 2 and 3 are ignored.
- R3: A write to address 0 sets the freeze bit from data bit 7 at once. Data bits 6:0 are only held aside: the tuning value and the read-back of address 0 keep their old upper bits until address 1 is written, which commits both bytes together as a 15-bit two's-complement offset.
- R4: A recompute is triggered by the first sample after reset, by a sample that differs from the temperature last used for compensation, or by a write to address 1. A sample equal to that temperature, with no write, triggers nothing: `done` stays 0 and `dac_code` is unchanged.
- R5: For a trigger sampled on clock edge N, `dac_code` takes its new value and `done` is high for exactly one cycle after edge N+3. `dac_code` changes at no other time.
- R6: Table entry k, for k = 0..255, belongs to temperature code 8*(k-80) (units of 0.0625 degrees) and holds 1500 + floor((k-128)^2 / 8).
- R7: For a code t in range, with i = floor(t/8)+80 and f = t - 8*floor(t/8), the trim is E(i) + floor((E(i+1)-E(i))*f / 8).
- R8: Codes below -640 use entry 0 and codes above 1400 use entry 255, with no interpolation.
- R9: `dac_code` = trim + tune, clamped to the range 0..4095.
- R10: While freeze is 1, samples still update the temperature register but trigger no recompute. A write to address 1 then recomputes with the held temperature and the new offset. After freeze is cleared, the next sample that differs from the held temperature recomputes.
- R11: A sample and a write to address 1 in the same cycle cause one recompute, which uses both the new temperature and the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | A new temperature sample is present |
| temp_in | input | 12 | Signed temperature, 0.0625 degree units |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| dac_code | output | 12 | Unsigned DAC code |
| done | output | 1 | One-cycle pulse when dac_code is loaded |

## Verification
A temperature sample and a commit of the low tuning byte can arrive on the same clock edge. Both are triggers, and the pipeline must merge them into a single recompute. The bench drives `temp_valid` and the address-1 write together and checks that `done` rises only three edges later and falls on the next cycle. It also checks that `dac_code` matches a value computed from the new temperature and the new offset together, not from either one alone.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int TEMP_W   = 12;
  localparam int DAC_W    = 12;
  localparam int TUNE_W   = 15;
  localparam int FRAC_W   = 3;
  localparam int ACC_W    = DAC_W + FRAC_W + 2;
  localparam int TRIM_DIV = 8;

  localparam logic signed [ACC_W-1:0] DAC_TOP = ACC_W'((1 << DAC_W) - 1);

  // Coarse trim curve: one entry per half degree.
  function automatic logic [DAC_W-1:0] trim_entry(input int idx, input int mid, input int knee);
    int d;
    d = idx - knee;
    return DAC_W'(mid + (d * d) / TRIM_DIV);
  endfunction

  // Linear interpolation in 1/8 steps, floor rounding.
  function automatic logic signed [ACC_W-1:0] lerp(input logic [DAC_W-1:0] lo,
                                                   input logic [DAC_W-1:0] hi,
                                                   input logic [FRAC_W-1:0] frac);
    logic signed [ACC_W-1:0] a, b, f, p;
    a = {{(ACC_W-DAC_W){1'b0}}, lo};
    b = {{(ACC_W-DAC_W){1'b0}}, hi};
    f = {{(ACC_W-FRAC_W){1'b0}}, frac};
    p = (b - a) * f;
    return a + (p >>> FRAC_W);
  endfunction

  // Add signed offset and clamp to the unsigned DAC range.
  function automatic logic [DAC_W-1:0] sat_sum(input logic signed [ACC_W-1:0] trim,
                                               input logic signed [TUNE_W-1:0] tune);
    logic signed [ACC_W-1:0] t, s;
    t = {{(ACC_W-TUNE_W){tune[TUNE_W-1]}}, tune};
    s = trim + t;
    if (s[ACC_W-1]) return '0;
    if (s > DAC_TOP) return '1;
    return s[DAC_W-1:0];
  endfunction
endpackage

// File: rtl/tct_regs.sv
module tct_regs
  import tct_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     temp_valid,
  input  logic signed [TEMP_W-1:0] temp_in,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [1:0]               rd_addr,
  output logic [7:0]               rd_data,
  output logic                     freeze,
  output logic signed [TUNE_W-1:0] tune_val,
  output logic signed [TEMP_W-1:0] temp_reg,
  output logic signed [TEMP_W-1:0] comp_temp,
  output logic                     temp_evt,
  output logic                     tune_evt,
  output logic                     start
);
  localparam logic [1:0] A_TUNE_HI = 2'd0;
  localparam logic [1:0] A_TUNE_LO = 2'd1;
  localparam logic [1:0] A_TEMP_HI = 2'd2;
  localparam int HI_W = TUNE_W - 8;

  logic [HI_W-1:0] shadow_q;
  logic            primed_q;

  assign tune_evt = wr_en && (wr_addr == A_TUNE_LO);
  assign temp_evt = temp_valid && !freeze && (!primed_q || (temp_in != comp_temp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze    <= 1'b0;
      shadow_q  <= '0;
      tune_val  <= '0;
      temp_reg  <= '0;
      comp_temp <= '0;
      primed_q  <= 1'b0;
      start     <= 1'b0;
    end else begin
      start <= temp_evt || tune_evt;
      if (temp_valid) temp_reg <= temp_in;
      if (temp_evt) begin
        comp_temp <= temp_in;
        primed_q  <= 1'b1;
      end
      if (wr_en && (wr_addr == A_TUNE_HI)) begin
        freeze   <= wr_data[7];
        shadow_q <= wr_data[HI_W-1:0];
      end
      if (tune_evt) tune_val <= {shadow_q, wr_data};
    end
  end

  always_comb begin
    case (rd_addr)
      A_TUNE_HI: rd_data = {freeze, tune_val[TUNE_W-1:8]};
      A_TUNE_LO: rd_data = tune_val[7:0];
      A_TEMP_HI: rd_data = temp_reg[TEMP_W-1:TEMP_W-8];
      default:   rd_data = {temp_reg[TEMP_W-9:0], {(16-TEMP_W){1'b0}}};
    endcase
  end
endmodule

// File: rtl/tct_lookup.sv
module tct_lookup
  import tct_pkg::*;
#(
  parameter int TBL_N     = 256,
  parameter int TBL_BASE  = -80,
  parameter int TRIM_MID  = 1500,
  parameter int TRIM_KNEE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_go,
  input  logic signed [TEMP_W-1:0] in_temp,
  input  logic signed [TUNE_W-1:0] in_tune,
  output logic                     out_v,
  output logic [DAC_W-1:0]         out_lo,
  output logic [DAC_W-1:0]         out_hi,
  output logic [FRAC_W-1:0]        out_frac,
  output logic signed [TUNE_W-1:0] out_tune
);
  localparam int IW    = $clog2(TBL_N);
  localparam int T_MIN = TBL_BASE * (1 << FRAC_W);
  localparam int T_MAX = (TBL_BASE + TBL_N - 1) * (1 << FRAC_W);

  logic [DAC_W-1:0]  rom [TBL_N];
  logic [IW-1:0]     lo_idx, hi_idx;
  logic [FRAC_W-1:0] frac;

  for (genvar g = 0; g < TBL_N; g++) begin : g_rom
    assign rom[g] = trim_entry(g, TRIM_MID, TRIM_KNEE);
  end

  always_comb begin
    int ti;
    int ii;
    ti = int'(in_temp);
    if (ti < T_MIN) ti = T_MIN;
    else if (ti > T_MAX) ti = T_MAX;
    ii     = (ti >>> FRAC_W) - TBL_BASE;
    lo_idx = IW'(ii);
    hi_idx = (ii >= TBL_N - 1) ? IW'(TBL_N - 1) : IW'(ii + 1);
    frac   = FRAC_W'(ti & ((1 << FRAC_W) - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_lo   <= '0;
      out_hi   <= '0;
      out_frac <= '0;
      out_tune <= '0;
    end else begin
      out_v <= in_go;
      if (in_go) begin
        out_lo   <= rom[lo_idx];
        out_hi   <= rom[hi_idx];
        out_frac <= frac;
        out_tune <= in_tune;
      end
    end
  end
endmodule

// File: rtl/tct_interp.sv
module tct_interp
  import tct_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_v,
  input  logic [DAC_W-1:0]         in_lo,
  input  logic [DAC_W-1:0]         in_hi,
  input  logic [FRAC_W-1:0]        in_frac,
  input  logic signed [TUNE_W-1:0] in_tune,
  output logic                     out_v,
  output logic signed [ACC_W-1:0]  out_trim,
  output logic signed [TUNE_W-1:0] out_tune
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_trim <= '0;
      out_tune <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        out_trim <= lerp(in_lo, in_hi, in_frac);
        out_tune <= in_tune;
      end
    end
  end
endmodule

// File: rtl/tct_sum.sv
module tct_sum
  import tct_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_v,
  input  logic signed [ACC_W-1:0]  in_trim,
  input  logic signed [TUNE_W-1:0] in_tune,
  output logic [DAC_W-1:0]         dac_code,
  output logic                     done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_code <= '0;
      done     <= 1'b0;
    end else begin
      done <= in_v;
      if (in_v) dac_code <= sat_sum(in_trim, in_tune);
    end
  end
endmodule

// File: rtl/tct_trim_ctrl.sv
module tct_trim_ctrl
  import tct_pkg::*;
#(
  parameter int TBL_N     = 256,
  parameter int TBL_BASE  = -80,
  parameter int TRIM_MID  = 1500,
  parameter int TRIM_KNEE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     temp_valid,
  input  logic signed [TEMP_W-1:0] temp_in,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [7:0]               wr_data,
  input  logic [1:0]               rd_addr,
  output logic [7:0]               rd_data,
  output logic [DAC_W-1:0]         dac_code,
  output logic                     done
);
  logic                     freeze, temp_evt, tune_evt, start;
  logic signed [TUNE_W-1:0] tune_val;
  logic signed [TEMP_W-1:0] temp_reg, comp_temp;

  logic                     look_v;
  logic [DAC_W-1:0]         look_lo, look_hi;
  logic [FRAC_W-1:0]        look_frac;
  logic signed [TUNE_W-1:0] look_tune;

  logic                     interp_v;
  logic signed [ACC_W-1:0]  interp_trim;
  logic signed [TUNE_W-1:0] interp_tune;

  tct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .freeze(freeze), .tune_val(tune_val), .temp_reg(temp_reg),
    .comp_temp(comp_temp), .temp_evt(temp_evt), .tune_evt(tune_evt), .start(start)
  );

  tct_lookup #(
    .TBL_N(TBL_N), .TBL_BASE(TBL_BASE), .TRIM_MID(TRIM_MID), .TRIM_KNEE(TRIM_KNEE)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n), .in_go(start), .in_temp(comp_temp), .in_tune(tune_val),
    .out_v(look_v), .out_lo(look_lo), .out_hi(look_hi), .out_frac(look_frac),
    .out_tune(look_tune)
  );

  tct_interp u_interp (
    .clk(clk), .rst_n(rst_n), .in_v(look_v), .in_lo(look_lo), .in_hi(look_hi),
    .in_frac(look_frac), .in_tune(look_tune), .out_v(interp_v),
    .out_trim(interp_trim), .out_tune(interp_tune)
  );

  tct_sum u_sum (
    .clk(clk), .rst_n(rst_n), .in_v(interp_v), .in_trim(interp_trim),
    .in_tune(interp_tune), .dac_code(dac_code), .done(done)
  );
endmodule

// File: rtl/tct_chk.sv
module tct_chk
  import tct_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     temp_valid,
  input logic signed [TEMP_W-1:0] temp_in,
  input logic                     wr_en,
  input logic [1:0]               wr_addr,
  input logic                     freeze,
  input logic                     tune_evt,
  input logic                     start,
  input logic signed [TUNE_W-1:0] tune_val,
  input logic signed [TEMP_W-1:0] temp_reg,
  input logic [DAC_W-1:0]         dac_code,
  input logic                     done
);
  // R5
  start_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##3 done);

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dac_code));

  // R4
  no_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_valid && !tune_evt) |=> !start);

  // R10
  freeze_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !tune_evt) |=> !start);

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> $stable(tune_val));

  // R2
  temp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid |=> (temp_reg == $past(temp_in)));
endmodule

bind tct_trim_ctrl tct_chk u_chk (
  .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
  .wr_en(wr_en), .wr_addr(wr_addr), .freeze(freeze), .tune_evt(tune_evt),
  .start(start), .tune_val(tune_val), .temp_reg(temp_reg),
  .dac_code(dac_code), .done(done)
);

// File: tb/tct_trim_ctrl_tb.sv
`timescale 1ns/100ps
module tct_trim_ctrl_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              temp_valid = 1'b0;
  logic signed [11:0] temp_in = '0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [7:0]        rd_data;
  logic [11:0]       dac_code;
  logic              done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tct_trim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .dac_code(dac_code), .done(done)
  );

  typedef struct packed { int t; int tune; } vec_t;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{t: 0,     tune: 0},
    '{t: 5,     tune: 0},
    '{t: -1,    tune: 0},
    '{t: -9,    tune: 100},
    '{t: 800,   tune: -300},
    '{t: -640,  tune: 0},
    '{t: 1400,  tune: 0},
    '{t: 1401,  tune: 50},
    '{t: -2000, tune: 0},
    '{t: 2000,  tune: 0},
    '{t: 100,   tune: 16383},
    '{t: -200,  tune: -16384},
    '{t: 37,    tune: -5}
  };

  function automatic int floor8(int x);
    if (x >= 0) return x / 8;
    return -((-x + 7) / 8);
  endfunction

  function automatic int tbl(int k);
    return 1500 + ((k - 128) * (k - 128)) / 8;
  endfunction

  function automatic int expect_dac(int t, int tune);
    int tc, i, f, lo, hi, s;
    tc = t;
    if (tc < -640) tc = -640;
    if (tc > 1400) tc = 1400;
    i  = floor8(tc) + 80;
    f  = tc - 8 * floor8(tc);
    lo = tbl(i);
    hi = (i < 255) ? tbl(i + 1) : lo;
    s  = lo + floor8((hi - lo) * f) + tune;
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sample(input int t);
    temp_valid = 1'b1; temp_in = 12'(t);
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic set_tune(input bit frz, input int tune);
    logic [14:0] tv;
    tv = 15'(tune);
    write_reg(2'd0, {frz, tv[14:8]});
    write_reg(2'd1, tv[7:0]);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    int held;
    int last_dac;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 dac", int'(dac_code), 0);
    chk("R1 done", int'(done), 0);
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), d);
      chk("R1 reg", d, 0);
    end

    // R6 R7 R8 R9 vector walk
    for (int v = 0; v < NV; v++) begin
      set_tune(1'b0, VECS[v].tune);
      repeat (5) @(negedge clk);
      sample(VECS[v].t);
      repeat (3) @(negedge clk);
      chk("R5 done pulse", int'(done), 1);
      chk("R7 R8 R9 dac", int'(dac_code), expect_dac(VECS[v].t, VECS[v].tune));
      @(negedge clk);
    end
    held = VECS[NV-1].t;

    // R4 equal sample gives no recompute
    last_dac = int'(dac_code);
    sample(held);
    for (int c = 0; c < 5; c++) begin
      chk("R4 no done", int'(done), 0);
      @(negedge clk);
    end
    chk("R4 dac unchanged", int'(dac_code), last_dac);

    // R10 freeze holds temperature trim, tuning stays live
    write_reg(2'd0, 8'h80);
    read_reg(2'd0, d);
    chk("R10 freeze bit", (d >> 7) & 1, 1);
    sample(300);
    for (int c = 0; c < 5; c++) begin
      chk("R10 no done while frozen", int'(done), 0);
      @(negedge clk);
    end
    read_reg(2'd2, d);
    chk("R10 R2 temp hi", d, (300 >> 4) & 255);
    read_reg(2'd3, d);
    chk("R10 R2 temp lo", d, (300 & 15) << 4);
    write_reg(2'd1, 8'h10);
    repeat (3) @(negedge clk);
    chk("R10 done on tune", int'(done), 1);
    chk("R10 held trim + tune", int'(dac_code), expect_dac(held, 16));
    @(negedge clk);
    write_reg(2'd0, 8'h00);
    sample(300);
    repeat (3) @(negedge clk);
    chk("R10 unfreeze done", int'(done), 1);
    chk("R10 unfreeze dac", int'(dac_code), expect_dac(300, 16));
    repeat (2) @(negedge clk);

    // R11 and R5: sample and low-byte write in the same cycle
    temp_valid = 1'b1; temp_in = -12'sd100;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h20;
    @(negedge clk);
    temp_valid = 1'b0; wr_en = 1'b0;
    chk("R5 latency n1", int'(done), 0);
    @(negedge clk);
    chk("R5 latency n2", int'(done), 0);
    @(negedge clk);
    chk("R5 latency n3", int'(done), 0);
    @(negedge clk);
    chk("R11 done", int'(done), 1);
    chk("R11 dac", int'(dac_code), expect_dac(-100, 32));
    @(negedge clk);
    chk("R11 single pulse", int'(done), 0);

    // R2 temperature bytes are read-only
    last_dac = int'(dac_code);
    write_reg(2'd2, 8'hFF);
    write_reg(2'd3, 8'hFF);
    read_reg(2'd2, d);
    chk("R2 temp hi", d, 8'hF9);
    read_reg(2'd3, d);
    chk("R2 temp lo", d, 8'hC0);
    repeat (3) @(negedge clk);
    chk("R2 no recompute", int'(done), 0);
    chk("R2 dac unchanged", int'(dac_code), last_dac);

    // R3 high byte is held until the low byte commits
    write_reg(2'd0, 8'h12);
    read_reg(2'd0, d);
    chk("R3 hi not yet visible", d, 8'h00);
    read_reg(2'd1, d);
    chk("R3 lo unchanged", d, 8'h20);
    for (int c = 0; c < 4; c++) begin
      chk("R3 no done on hi write", int'(done), 0);
      @(negedge clk);
    end
    write_reg(2'd1, 8'h34);
    read_reg(2'd0, d);
    chk("R3 hi committed", d, 8'h12);
    read_reg(2'd1, d);
    chk("R3 lo committed", d, 8'h34);
    repeat (3) @(negedge clk);
    chk("R3 R9 saturated dac", int'(dac_code), expect_dac(-100, 16'h1234));

    // R6 table entries at exact grid points
    set_tune(1'b0, 0);
    repeat (5) @(negedge clk);
    for (int k = 0; k < 256; k += 51) begin
      sample(8 * (k - 80));
      repeat (3) @(negedge clk);
      chk("R6 entry", int'(dac_code), 1500 + ((k - 128) * (k - 128)) / 8);
      @(negedge clk);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule